// File: doc/BRIEF.md
# Two-wire serial memory slave with 17-bit addressing

This block is the protocol engine of a serial byte memory that answers on a two-wire bus. It watches the clock and data lines through an open-drain pad pair, recognises START and STOP, decodes the device byte and two word-address bytes into a 17-bit array address, and moves data between the bus and an external 128K x 8 array port. The top address bit travels inside the device byte. The low 16 bits follow in two bytes, high byte first.

Writes are staged in a one-page buffer and committed to the array only after the STOP. A timed busy window follows each commit, and the device refuses its own address during that window so that a host can poll for completion. Reads return bytes from an internal address pointer. The pointer can be set by a dummy write, or used as left by the previous access. It advances for every byte sent and stays live across a master acknowledge. A separate permission input decides whether data bytes are accepted at all.

Top module: `eep_i2c_slave`

## Requirements
- R1: The device byte is matched MSB first as 1010, then 0, then the level of `a1_i`; bit 1 is address bit 16 and bit 0 is the direction (1 = read). On a mismatch the byte is not acknowledged and every following bit is ignored until the next START.
- R2: After a write-direction device byte that matches, bit 1 of it becomes address bit 16, the next byte gives address bits 15..8 and the one after gives bits 7..0; each of the three bytes is acknowledged. A read-direction device byte leaves the pointer unchanged.
- R3: Data bytes of a write reach the array only after the STOP that ends the transfer, one byte per clock on `mem_we_o`; a START without a STOP discards bytes not yet committed.
- R4: In a write, every data byte is acknowledged and only address bits 6..0 advance, so the bytes wrap within one 128-byte page; bytes past the 128th replace the ones buffered earlier at the same offset, and only offsets that received a byte are written.
- R5: A STOP that commits data opens a busy window of `BUSY_CYC` clocks; during it a matching device byte gets no acknowledge, and after it the device acknowledges again.
- R6: A read with no address phase starts at the pointer, which holds the last accessed address plus one. After a write it advances only within the page; after a read it is the full 17-bit increment.
- R7: A random read (write-direction device byte, two address bytes, repeated START, read-direction device byte) returns the byte at the given address.
- R8: In a read, each master acknowledge makes the next byte follow at the full 17-bit increment, wrapping from 0x1FFFF to 0; a master non-acknowledge ends the transfer and releases the line.
- R9: With `wr_en_i` low the device and both address bytes are still acknowledged, but the first data byte is not, nothing is committed and no busy window opens.
- R10: The device changes its drive on SDA only while SCL is low. It drives the acknowledge low during the ninth clock and sends read data MSB first.
- R11: A repeated START at any point returns the engine to the device-byte phase.
- R12: Array reads have one clock of latency: `mem_rdata_i` reflects `mem_addr_o` from the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| a1_i | input | 1 | Strap level compared with device-byte bit 2 |
| wr_en_i | input | 1 | Write permission; low refuses data bytes |
| sda_oe_o | output | 1 | Pull SDA low when high (open drain) |
| mem_addr_o | output | 17 | Array address (pointer, or commit address during a commit) |
| mem_rdata_i | input | 8 | Array read data, one clock after the address |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Bus inputs pass two synchroniser stages and an edge register. Every change of `sda_oe_o` therefore lands about three clocks after the SCL edge that caused it. The bench holds each SCL phase for six clocks and samples the line just before SCL falls, which is long after that change has settled. Array contents are compared only after the busy window plus a margin has passed, because a commit may take up to 128 clocks after the STOP. The model predicts each acknowledge, read byte and pointer position from the requirements alone.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int EEP_ADDR_W = 17;
  localparam int EEP_PG_W   = 7;
  localparam int EEP_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AH,
    ST_AL,
    ST_WR,
    ST_RD
  } eep_state_e;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
#(
  parameter int ADDR_W = EEP_ADDR_W,
  parameter int PG_W   = EEP_PG_W,
  parameter int DW     = EEP_BYTE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [PG_W-1:0]        wr_idx_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic                   clr_i,
  input  logic                   commit_i,
  input  logic [ADDR_W-PG_W-1:0] page_i,
  output logic                   pending_o,
  output logic                   active_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o
);
  localparam int PAGE = 1 << PG_W;

  logic [DW-1:0]          data_q [PAGE];
  logic [PAGE-1:0]        vld_q;
  logic [PG_W-1:0]        idx_q;
  logic                   active_q;
  logic [ADDR_W-PG_W-1:0] page_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) data_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      page_q   <= '0;
    end else if (active_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == PG_W'(PAGE - 1)) begin
        active_q <= 1'b0;
        vld_q    <= '0;
      end
    end else if (commit_i && pending_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      page_q   <= page_i;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (wr_i) begin
      vld_q[wr_idx_i] <= 1'b1;
    end
  end

  assign pending_o   = |vld_q;
  assign active_o    = active_q;
  assign mem_we_o    = active_q & vld_q[idx_q];
  assign mem_addr_o  = {page_q, idx_q};
  assign mem_wdata_o = data_q[idx_q];
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int BUSY_CYC    = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  a1_i,
  input  logic                  wr_en_i,
  output logic                  sda_oe_o,
  output logic [EEP_ADDR_W-1:0] mem_addr_o,
  input  logic [EEP_BYTE_W-1:0] mem_rdata_i,
  output logic                  mem_we_o,
  output logic [EEP_BYTE_W-1:0] mem_wdata_o
);
  localparam int AW    = EEP_ADDR_W;
  localparam int PW    = EEP_PG_W;
  localparam int DW    = EEP_BYTE_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eep_state_e    state_q, nxt_q, nxt_d;
  logic [3:0]    cnt_q;
  logic          in_ack_q, ack_q, mack_q, sda_oe_q, ack_ok;
  logic [DW-1:0] sh_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          busy_q;
  logic [CNT_W-1:0] bcnt_q;
  logic          ev_byte, buf_wr, pending, cm_active, commit_go;
  logic [AW-1:0] cm_addr;

  // one received byte complete: falling edge that opens the ack clock
  assign ev_byte = (state_q inside {ST_DEV, ST_AH, ST_AL, ST_WR}) &&
                   scl_fall && !in_ack_q && (cnt_q == 4'd8);

  always_comb begin
    ack_ok = 1'b0;
    nxt_d  = ST_IDLE;
    unique case (state_q)
      ST_DEV: begin
        ack_ok = (sh_q[7:4] == 4'b1010) && !sh_q[3] && (sh_q[2] == a1_i) && !busy_q;
        nxt_d  = sh_q[0] ? ST_RD : ST_AH;
      end
      ST_AH:   begin ack_ok = 1'b1;    nxt_d = ST_AL; end
      ST_AL:   begin ack_ok = 1'b1;    nxt_d = ST_WR; end
      ST_WR:   begin ack_ok = wr_en_i; nxt_d = ST_WR; end
      default: begin ack_ok = 1'b0;    nxt_d = ST_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      ack_q    <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
    end else if (start_det) begin
      state_q  <= ST_DEV;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      in_ack_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (in_ack_q) mack_q <= ~sda_s;
        else if (cnt_q < 4'd8) begin
          cnt_q <= cnt_q + 1'b1;
          if (state_q != ST_RD) sh_q <= {sh_q[DW-2:0], sda_s};
        end
      end
      if (scl_fall) begin
        if (state_q == ST_RD) begin
          if (!in_ack_q) begin
            if (cnt_q == 4'd8) begin
              in_ack_q <= 1'b1;
              sda_oe_q <= 1'b0;
              ptr_q    <= ptr_q + 1'b1;
            end else begin
              tx_q     <= {tx_q[DW-2:0], 1'b0};
              sda_oe_q <= ~tx_q[DW-2];
            end
          end else begin
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            if (mack_q) begin
              tx_q     <= mem_rdata_i;
              sda_oe_q <= ~mem_rdata_i[DW-1];
            end else begin
              state_q  <= ST_IDLE;
              sda_oe_q <= 1'b0;
            end
          end
        end else if (ev_byte) begin
          in_ack_q <= 1'b1;
          ack_q    <= ack_ok;
          sda_oe_q <= ack_ok;
          nxt_q    <= nxt_d;
          if (ack_ok) begin
            unique case (state_q)
              ST_DEV:  if (!sh_q[0]) ptr_q[AW-1] <= sh_q[1];
              ST_AH:   ptr_q[AW-2 -: DW] <= sh_q;
              ST_AL:   ptr_q[DW-1:0] <= sh_q;
              ST_WR:   ptr_q[PW-1:0] <= ptr_q[PW-1:0] + 1'b1;
              default: ;
            endcase
          end
        end else if (in_ack_q) begin
          in_ack_q <= 1'b0;
          cnt_q    <= '0;
          if (ack_q && nxt_q == ST_RD) begin
            state_q  <= ST_RD;
            tx_q     <= mem_rdata_i;
            sda_oe_q <= ~mem_rdata_i[DW-1];
          end else begin
            state_q  <= ack_q ? nxt_q : ST_IDLE;
            sda_oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign buf_wr    = ev_byte && (state_q == ST_WR) && wr_en_i;
  assign commit_go = stop_det && pending && !busy_q;

  eep_page_buf #(.ADDR_W(AW), .PG_W(PW), .DW(DW)) u_pbuf (
    .clk_i, .rst_ni,
    .wr_i(buf_wr), .wr_idx_i(ptr_q[PW-1:0]), .wr_data_i(sh_q),
    .clr_i(start_det && !busy_q), .commit_i(commit_go),
    .page_i(ptr_q[AW-1:PW]),
    .pending_o(pending), .active_o(cm_active),
    .mem_we_o(mem_we_o), .mem_addr_o(cm_addr), .mem_wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
    end else if (commit_go) begin
      busy_q <= 1'b1;
      bcnt_q <= CNT_W'(BUSY_CYC - 1);
    end else if (busy_q) begin
      if (bcnt_q == '0) busy_q <= 1'b0;
      else              bcnt_q <= bcnt_q - 1'b1;
    end
  end

  assign sda_oe_o   = sda_oe_q;
  assign mem_addr_o = cm_active ? cm_addr : ptr_q;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic                  mem_we_o,
  input logic [EEP_ADDR_W-1:0] mem_addr_o,
  input logic                  busy_i,
  input logic                  stop_i,
  input eep_state_e            state_i
);
  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  a_r5_busy_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  a_r5_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (state_i == ST_IDLE || state_i == ST_DEV));

  a_r3_we_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_i);

  a_r4_one_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[EEP_ADDR_W-1:EEP_PG_W] == $past(mem_addr_o[EEP_ADDR_W-1:EEP_PG_W])));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && $past(state_i) == ST_IDLE) |-> !sda_oe_o);
endmodule

bind eep_i2c_slave eep_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .busy_i(busy_q), .stop_i(stop_det), .state_i(state_q)
);

// File: tb/eep_i2c_slave_bench.sv
`timescale 1ns/1ps
module eep_i2c_slave_bench;
  localparam int BUSY = 400;
  localparam int Q    = 6;
  localparam int AMSK = 'h1FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, a1 = 1'b1, wr_en = 1'b1;
  logic sda_oe, mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_rdata = 8'hFF, mem_wdata;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eep_i2c_slave #(.BUSY_CYC(BUSY)) u_eep_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .a1_i(a1), .wr_en_i(wr_en), .sda_oe_o(sda_oe),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  logic [7:0] ram [int];
  always @(posedge clk) begin
    if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'hFF;
  end

  // reference model state
  logic [7:0] ref_mem [int];
  int ref_ptr = 0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] ram_rd(int a);
    return ram.exists(a) ? ram[a] : 8'hFF;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bclk(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
    s = sda_line; scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bclk(d[i], s);
    bclk(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin bclk(1'b1, s); d = {d[6:0], s}; end
    bclk(!give_ack, s);
  endtask

  function automatic logic [7:0] dev(logic a1b, int top, logic rd);
    return {4'b1010, 1'b0, a1b, top[0], rd};
  endfunction

  task automatic poll(logic exp_ack, string tag);
    logic ack;
    bstart(); wbyte(dev(a1, (ref_ptr >> 16) & 1, 1'b0), ack); bstop();
    chk(ack == exp_ack, tag, ack, exp_ack);
  endtask

  task automatic do_write(int a, int n, logic [7:0] base);
    logic ack;
    logic [7:0] pb [int];
    int p;
    bstart();
    wbyte(dev(a1, (a >> 16) & 1, 1'b0), ack); chk(ack, "R1 dev ack", ack, 1);
    wbyte(a[15:8], ack); chk(ack, "R2 addr hi ack", ack, 1);
    wbyte(a[7:0], ack);  chk(ack, "R2 addr lo ack", ack, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = base + 8'(k * 13);
      wbyte(d, ack);
      chk(ack == wr_en, wr_en ? "R4 data ack" : "R9 data nack", ack, wr_en);
      if (!wr_en) break;
      pb[p] = d;
      p = (p & ~127) | ((p + 1) & 127);
    end
    bstop();
    if (wr_en && n > 0) begin
      ref_ptr = p;
      foreach (pb[key]) ref_mem[key] = pb[key];
      poll(1'b0, "R5 busy nack");
      tick(BUSY + 20);
      poll(1'b1, "R5 ready ack");
      foreach (pb[key]) chk(ram_rd(key) == ref_rd(key), "R3 R4 committed byte", ram_rd(key), ref_rd(key));
    end else begin
      ref_ptr = a;
      poll(1'b1, "R9 no busy window");
      chk(ram_rd(a) == ref_rd(a), "R9 array untouched", ram_rd(a), ref_rd(a));
    end
  endtask

  task automatic do_read(int a, int n, string tag);
    logic ack;
    logic [7:0] d;
    if (a >= 0) begin
      bstart();
      wbyte(dev(a1, (a >> 16) & 1, 1'b0), ack);
      wbyte(a[15:8], ack);
      wbyte(a[7:0], ack);
      ref_ptr = a;
    end
    bstart();
    wbyte(dev(a1, 0, 1'b1), ack);
    chk(ack, "R11 read dev ack after restart", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, d);
      chk(d == ref_rd(ref_ptr), tag, d, ref_rd(ref_ptr));
      ref_ptr = (ref_ptr + 1) & AMSK;
    end
    bstop();
    chk(sda_oe == 1'b0, "R8 line released", sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic ack;
    tick(3); rst_n = 1'b1; tick(5);
    chk(sda_oe == 1'b0, "R1 reset no drive", sda_oe, 0);
    chk(mem_we == 1'b0, "R3 reset no write", mem_we, 0);

    do_write('h12345, 1, 8'hA5);                // R3 byte write
    do_read('h12345, 1, "R7 random read");
    do_read(-1, 1, "R6 current read after read");

    do_write('h00470, 20, 8'h10);               // R4 wrap inside page
    do_read('h0047C, 8, "R8 sequential across page");
    do_write('h00800, 130, 8'h21);              // R4 overflow
    do_read('h00800, 3, "R4 overwritten head");

    // R1 wrong strap and wrong type nibble
    bstart(); wbyte(dev(!a1, 0, 1'b0), ack);
    chk(!ack, "R1 strap mismatch nack", ack, 0);
    wbyte(8'h00, ack); chk(!ack, "R1 ignored until start", ack, 0);
    bstop();
    bstart(); wbyte({4'b1011, 1'b0, a1, 2'b00}, ack);
    chk(!ack, "R1 type mismatch nack", ack, 0);
    bstop();

    wr_en = 1'b0;
    do_write('h00900, 1, 8'h99);                // R9
    wr_en = 1'b1;
    do_read('h00900, 1, "R9 read back unchanged");

    do_write('h00000, 1, 8'h3C);
    do_write('h1FF80, 1, 8'h77);
    do_write('h1FFFF, 1, 8'h5A);
    do_read(-1, 1, "R6 current read page wrap after write");
    do_read('h1FFFF, 2, "R8 wrap top to zero");
    do_read(-1, 1, "R12 current read after wrap");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule